// File: doc/BRIEF.md
# Exception Priority Resolver with Vector Address

This block chooses which exception a processor core should take next. Each cycle it looks at a vector of pending requests, one bit per exception number, and picks a winner. Reset, the non-maskable interrupt and the hard fault have fixed ranks above all others. Every other selectable exception gets a small programmable priority level, which is written through a one-entry-per-cycle write port. Peripheral interrupt line n is exception number 16+n, so the default configuration covers exception numbers 0 to 255.

The winner's number and its vector-table address (the number times four) come out registered, one cycle after the pending vector and priority state they were computed from. A take flag tells the core whether the winner should preempt the code now running. The core gives the rank of that code on `activeRank`. The flag is raised only when the winner is strictly more urgent.

Top module: `excResolver`

## Requirements
- R1: After reset, all outputs are 0 and every programmable priority level is 0.
- R2: Exception 1 outranks exception 2, exception 2 outranks exception 3, and exception 3 outranks every programmable exception, whatever the programmable levels hold.
- R3: Among programmable exceptions (number 4 and above, except reserved numbers), a smaller 2-bit level wins.
- R4: When pending exceptions tie on effective rank, the lowest exception number wins.
- R5: Exception numbers 0, 7, 8, 9, 10 and 13 are never selected, even when they are the only pending bits. With no selectable pending bit, `pickValid` is 0 and `pickNum`, `pickVector` and `takeValid` are 0.
- R6: `pickVector` equals `pickNum` times 4. Peripheral line 239 is exception 255 at address 0x3FC, and line 0 is exception 16 at address 0x40.
- R7: Outputs at the cycle after a rising edge reflect the pending vector and priority levels sampled at that edge: one cycle of latency.
- R8: `activeRank` codes 0, 1 and 2 stand for exceptions 1, 2 and 3. Code 3+L stands for programmable level L, and code 7 stands for thread mode. The winner's rank uses the same code. `takeValid` is 1 only when a winner exists and its rank code is strictly below `activeRank`.
- R9: A priority write with index 4 or above sets that exception's level from the next edge on; a pending vector sampled at the write edge still sees the old level. A write with index 0 to 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| pendReq | input | 256 | Pending request per exception number |
| prioWrEn | input | 1 | Priority write strobe |
| prioWrIdx | input | 8 | Exception number whose level is written |
| prioWrData | input | 2 | New priority level, 0 is most urgent |
| activeRank | input | 3 | Rank code of the code now running (7 = thread mode) |
| pickValid | output | 1 | A selectable exception is pending |
| pickNum | output | 8 | Winning exception number |
| pickVector | output | 10 | Vector-table byte address of the winner |
| takeValid | output | 1 | Winner should preempt the active code |

## Verification
The bench drives reserved numbers alone, to show that a design that forgets the holes in the numbering would report a phantom winner with a vector into reserved space. It drives equal-level ties, where an arbiter that favours the right-hand branch would report the higher number. It drives the active rank equal to the winner's rank, which a comparison written as less-or-equal would wrongly turn into a preemption. It also issues a write in the same cycle as a pending pulse, and writes to the fixed slots, which a design with write-through or ungated writes would let change the outcome.

// File: rtl/excPkg.sv
package excPkg;
  // Exceptions 1..3 carry fixed ranks 0..2; programmable ranks start after them.
  localparam int FIXED_COUNT = 3;

  typedef struct packed {
    logic prioWe;    // commit a priority write this edge
    logic takeNext;  // winner preempts the active code
  } ctrlStrobe_t;

  // Numbers that may ever be chosen: not the stack slot and not the reserved holes.
  function automatic logic isSelectable(input int unsigned num);
    return (num != 0) && !((num >= 7) && (num <= 10)) && (num != 13);
  endfunction
endpackage

// File: rtl/excControl.sv
module excControl #(
  parameter int EXC_W  = 8,
  parameter int RANK_W = 3
) (
  input  logic              wrEn,
  input  logic [EXC_W-1:0]  wrIdx,
  input  logic              winValid,
  input  logic [RANK_W-1:0] winRank,
  input  logic [RANK_W-1:0] activeRank,
  output excPkg::ctrlStrobe_t strobes
);
  localparam logic [EXC_W-1:0] FIRST_PROG = EXC_W'(excPkg::FIXED_COUNT + 1);

  always_comb begin
    strobes.prioWe   = wrEn && (wrIdx >= FIRST_PROG);
    strobes.takeNext = winValid && (winRank < activeRank);
  end
endmodule

// File: rtl/excDatapath.sv
module excDatapath #(
  parameter int NUM_EXC = 256,
  parameter int PRIO_W  = 2,
  parameter int EXC_W   = 8,
  parameter int RANK_W  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_EXC-1:0]  pendReq,
  input  excPkg::ctrlStrobe_t strobes,
  input  logic [EXC_W-1:0]    wrIdx,
  input  logic [PRIO_W-1:0]   wrData,
  output logic                winValid,
  output logic [RANK_W-1:0]   winRank,
  output logic                pickValid,
  output logic [EXC_W-1:0]    pickNum,
  output logic [EXC_W+1:0]    pickVector,
  output logic                takeValid
);
  localparam int NODES = 2 * NUM_EXC;

  logic [PRIO_W-1:0] prioMem [NUM_EXC];
  logic              nodeValid [NODES];
  logic [RANK_W-1:0] nodeRank  [NODES];
  logic [EXC_W-1:0]  nodeNum   [NODES];

  // Programmable level storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_EXC; i++) prioMem[i] <= '0;
    end else if (strobes.prioWe) begin
      prioMem[wrIdx] <= wrData;
    end
  end

  // Leaves: one per exception number, heap positions NUM_EXC..2*NUM_EXC-1
  for (genvar gi = 0; gi < NUM_EXC; gi++) begin : gLeaf
    localparam logic SELECTABLE = excPkg::isSelectable(gi);
    assign nodeValid[NUM_EXC+gi] = pendReq[gi] && SELECTABLE;
    assign nodeNum[NUM_EXC+gi]   = EXC_W'(gi);
    if (gi >= 1 && gi <= excPkg::FIXED_COUNT) begin : gFixed
      assign nodeRank[NUM_EXC+gi] = RANK_W'(gi - 1);
    end else begin : gProg
      assign nodeRank[NUM_EXC+gi] = RANK_W'(excPkg::FIXED_COUNT) + RANK_W'(prioMem[gi]);
    end
  end

  // Binary reduction tree; left child always holds the lower numbers
  for (genvar gn = 1; gn < NUM_EXC; gn++) begin : gNode
    logic pickLeft;
    assign pickLeft = nodeValid[2*gn] &&
                      (!nodeValid[2*gn+1] || (nodeRank[2*gn] <= nodeRank[2*gn+1]));
    assign nodeValid[gn] = nodeValid[2*gn] || nodeValid[2*gn+1];
    assign nodeRank[gn]  = pickLeft ? nodeRank[2*gn] : nodeRank[2*gn+1];
    assign nodeNum[gn]   = pickLeft ? nodeNum[2*gn]  : nodeNum[2*gn+1];
  end

  assign nodeValid[0] = 1'b0;
  assign nodeRank[0]  = '0;
  assign nodeNum[0]   = '0;

  assign winValid = nodeValid[1];
  assign winRank  = nodeRank[1];

  // Registered result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pickValid  <= 1'b0;
      pickNum    <= '0;
      pickVector <= '0;
      takeValid  <= 1'b0;
    end else begin
      pickValid  <= nodeValid[1];
      pickNum    <= nodeValid[1] ? nodeNum[1] : '0;
      pickVector <= nodeValid[1] ? {nodeNum[1], 2'b00} : '0;
      takeValid  <= strobes.takeNext;
    end
  end
endmodule

// File: rtl/excResolver.sv
module excResolver #(
  parameter int NUM_EXC = 256,
  parameter int PRIO_W  = 2,
  localparam int EXC_W  = $clog2(NUM_EXC),
  localparam int VEC_W  = EXC_W + 2,
  localparam int RANK_W = $clog2(excPkg::FIXED_COUNT + (2 ** PRIO_W) + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXC-1:0] pendReq,
  input  logic               prioWrEn,
  input  logic [EXC_W-1:0]   prioWrIdx,
  input  logic [PRIO_W-1:0]  prioWrData,
  input  logic [RANK_W-1:0]  activeRank,
  output logic               pickValid,
  output logic [EXC_W-1:0]   pickNum,
  output logic [VEC_W-1:0]   pickVector,
  output logic               takeValid
);
  excPkg::ctrlStrobe_t strobes;
  logic                winValid;
  logic [RANK_W-1:0]   winRank;

  excControl #(.EXC_W(EXC_W), .RANK_W(RANK_W)) ctrl (
    .wrEn(prioWrEn), .wrIdx(prioWrIdx), .winValid(winValid),
    .winRank(winRank), .activeRank(activeRank), .strobes(strobes)
  );

  excDatapath #(.NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W), .EXC_W(EXC_W), .RANK_W(RANK_W)) dp (
    .clk(clk), .rstN(rstN), .pendReq(pendReq), .strobes(strobes),
    .wrIdx(prioWrIdx), .wrData(prioWrData), .winValid(winValid), .winRank(winRank),
    .pickValid(pickValid), .pickNum(pickNum), .pickVector(pickVector), .takeValid(takeValid)
  );
endmodule

// File: rtl/excResolverChk.sv
module excResolverChk #(
  parameter int NUM_EXC = 256,
  parameter int EXC_W   = 8,
  parameter int RANK_W  = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_EXC-1:0] pendReq,
  input logic [RANK_W-1:0]  activeRank,
  input logic               pickValid,
  input logic [EXC_W-1:0]   pickNum,
  input logic [EXC_W+1:0]   pickVector,
  input logic               takeValid
);
  logic [NUM_EXC-1:0] pendQ;
  logic [RANK_W-1:0]  activeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ   <= '0;
      activeQ <= '0;
    end else begin
      pendQ   <= pendReq;
      activeQ <= activeRank;
    end
  end

  assert_pick_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    pickValid |-> pendQ[pickNum]);
  assert_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ == '0) |-> (!pickValid && !takeValid));
  assert_no_reserved_R5: assert property (@(posedge clk) disable iff (!rstN)
    pickValid |-> excPkg::isSelectable(32'(pickNum)));
  assert_reset_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    pendQ[1] |-> (pickValid && pickNum == EXC_W'(1)));
  assert_nmi_second_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ[2] && !pendQ[1]) |-> (pickValid && pickNum == EXC_W'(2)));
  assert_vector_R6: assert property (@(posedge clk) disable iff (!rstN)
    pickVector == {pickNum, 2'b00});
  assert_take_needs_pick_R8: assert property (@(posedge clk) disable iff (!rstN)
    takeValid |-> pickValid);
  assert_top_active_R8: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ == '0) |-> !takeValid);
endmodule

bind excResolver excResolverChk #(.NUM_EXC(NUM_EXC), .EXC_W(EXC_W), .RANK_W(RANK_W)) chk (
  .clk(clk), .rstN(rstN), .pendReq(pendReq), .activeRank(activeRank),
  .pickValid(pickValid), .pickNum(pickNum), .pickVector(pickVector), .takeValid(takeValid)
);

// File: tb/excResolver_test.sv
module excResolver_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [255:0] pendReq = '0;
  logic         prioWrEn = 1'b0;
  logic [7:0]   prioWrIdx = '0;
  logic [1:0]   prioWrData = '0;
  logic [2:0]   activeRank = 3'd7;
  logic         pickValid, takeValid;
  logic [7:0]   pickNum;
  logic [9:0]   pickVector;

  int checks = 0;
  int failures = 0;
  bit cmpOn = 0;
  bit finished = 0;
  string curTag = "R1";

  int mPrio [256];
  bit eValid, eTake;
  int eNum;

  always #2 clk = ~clk;

  excResolver uut (
    .clk(clk), .rstN(rstN), .pendReq(pendReq), .prioWrEn(prioWrEn),
    .prioWrIdx(prioWrIdx), .prioWrData(prioWrData), .activeRank(activeRank),
    .pickValid(pickValid), .pickNum(pickNum), .pickVector(pickVector), .takeValid(takeValid)
  );

  function automatic bit legalNum(int n);
    return n != 0 && !(n >= 7 && n <= 10) && n != 13;
  endfunction

  function automatic int rankOf(int n);
    if (n >= 1 && n <= 3) return n - 1;
    return 3 + mPrio[n];
  endfunction

  // Behavioural reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      eValid = 0; eNum = 0; eTake = 0;
      for (int i = 0; i < 256; i++) mPrio[i] = 0;
    end else begin
      int bestRank;
      eValid = 0; eNum = 0; bestRank = 99;
      for (int n = 0; n < 256; n++) begin
        if (pendReq[n] && legalNum(n) && rankOf(n) < bestRank) begin
          bestRank = rankOf(n); eNum = n; eValid = 1;
        end
      end
      eTake = eValid && (bestRank < int'(activeRank));
      if (prioWrEn && prioWrIdx >= 8'd4) mPrio[prioWrIdx] = int'(prioWrData);
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmpOn) begin
      checks++;
      if (pickValid !== eValid || int'(pickNum) != eNum || int'(pickVector) != eNum * 4
          || takeValid !== eTake) begin
        failures++;
        $display("FAIL %s: valid/num/vec/take actual %0d/%0d/%0h/%0d expected %0d/%0d/%0h/%0d",
                 curTag, pickValid, pickNum, pickVector, takeValid, eValid, eNum, eNum * 4, eTake);
      end
    end
  end

  task automatic expectNow(bit v, int num, bit tk, string tag);
    checks++;
    if (pickValid !== v || int'(pickNum) != num || int'(pickVector) != num * 4 || takeValid !== tk) begin
      failures++;
      $display("FAIL %s: valid/num/take actual %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, pickValid, pickNum, takeValid, v, num, tk);
    end
  endtask

  task automatic writePrio(int idx, int lvl);
    @(negedge clk);
    pendReq = '0; prioWrEn = 1'b1; prioWrIdx = 8'(idx); prioWrData = 2'(lvl);
    @(negedge clk);
    prioWrEn = 1'b0;
  endtask

  // Present a pending set for one cycle, then look at the result
  task automatic pulse(logic [255:0] p, logic [2:0] act);
    @(negedge clk);
    pendReq = p; activeRank = act;
    @(negedge clk);
    pendReq = '0;
  endtask

  function automatic logic [255:0] bits3(int a, int b, int c);
    logic [255:0] v = '0;
    if (a >= 0) v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    if (c >= 0) v[c] = 1'b1;
    return v;
  endfunction

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmpOn = 1;
    curTag = "R1";
    expectNow(0, 0, 0, "R1");
    @(negedge clk); rstN = 1'b1;
    // R1: all levels start at 0, so a tie resolves by number
    pulse(bits3(20, 16, -1), 3'd7); expectNow(1, 16, 1, "R1");

    curTag = "R3";
    writePrio(16, 2); writePrio(20, 1);
    pulse(bits3(16, 20, -1), 3'd7); expectNow(1, 20, 1, "R3");
    writePrio(40, 0);
    pulse(bits3(16, 20, 40), 3'd7); expectNow(1, 40, 1, "R3");

    curTag = "R4";
    writePrio(30, 1); writePrio(25, 1);
    pulse(bits3(30, 25, -1), 3'd7); expectNow(1, 25, 1, "R4");
    pulse(bits3(30, 25, 20), 3'd7); expectNow(1, 20, 1, "R4");

    curTag = "R2";
    pulse(bits3(3, 40, -1), 3'd7); expectNow(1, 3, 1, "R2");
    pulse(bits3(2, 3, 40), 3'd7); expectNow(1, 2, 1, "R2");
    pulse(bits3(1, 2, 3), 3'd7); expectNow(1, 1, 1, "R2");

    curTag = "R5";
    pulse(bits3(0, 7, 13), 3'd7); expectNow(0, 0, 0, "R5");
    pulse(bits3(8, 9, 10), 3'd7); expectNow(0, 0, 0, "R5");
    pulse(bits3(0, 13, 255), 3'd7); expectNow(1, 255, 1, "R5");

    curTag = "R6";
    pulse(bits3(255, -1, -1), 3'd7); expectNow(1, 255, 1, "R6");
    checks++;
    if (pickVector !== 10'h3FC) begin
      failures++; $display("FAIL R6: vector actual %0h expected 3fc", pickVector);
    end
    pulse(bits3(16, -1, -1), 3'd7);
    checks++;
    if (pickVector !== 10'h040) begin
      failures++; $display("FAIL R6: vector actual %0h expected 40", pickVector);
    end

    curTag = "R8";
    // exception 20 has level 1 -> rank code 4
    pulse(bits3(20, -1, -1), 3'd4); expectNow(1, 20, 0, "R8");
    pulse(bits3(20, -1, -1), 3'd5); expectNow(1, 20, 1, "R8");
    pulse(bits3(20, -1, -1), 3'd3); expectNow(1, 20, 0, "R8");
    pulse(bits3(2, -1, -1), 3'd1);  expectNow(1, 2, 0, "R8");
    pulse(bits3(2, -1, -1), 3'd2);  expectNow(1, 2, 1, "R8");
    pulse(bits3(1, -1, -1), 3'd0);  expectNow(1, 1, 0, "R8");

    curTag = "R7";
    @(negedge clk); pendReq = bits3(40, -1, -1); activeRank = 3'd7;
    checks++;
    if (pickValid !== 1'b0) begin
      failures++; $display("FAIL R7: early valid actual %0d expected 0", pickValid);
    end
    @(negedge clk); pendReq = '0; expectNow(1, 40, 1, "R7");
    @(negedge clk); expectNow(0, 0, 0, "R7");

    curTag = "R9";
    // same-edge write: old level 1 of 20 vs level 0 of 40 -> 40 still wins
    @(negedge clk);
    pendReq = bits3(20, 40, -1); prioWrEn = 1'b1; prioWrIdx = 8'd40; prioWrData = 2'd3;
    @(negedge clk);
    prioWrEn = 1'b0; expectNow(1, 40, 1, "R9");
    @(negedge clk); pendReq = '0; expectNow(1, 20, 1, "R9");
    // writes to fixed slots change nothing: exception 3 keeps outranking level 0
    writePrio(3, 3); writePrio(2, 3); writePrio(5, 0);
    pulse(bits3(3, 5, -1), 3'd3); expectNow(1, 3, 1, "R9");
    pulse(bits3(2, 3, -1), 3'd7); expectNow(1, 2, 1, "R9");

    curTag = "R3 random";
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      pendReq = '0;
      for (int k = 0; k < 4; k++) pendReq[$urandom_range(4, 255)] = 1'b1;
      if ($urandom_range(0, 9) == 0) pendReq[$urandom_range(1, 3)] = 1'b1;
      if ($urandom_range(0, 7) == 0) pendReq = '0;
      activeRank = 3'($urandom_range(0, 7));
      prioWrEn = ($urandom_range(0, 2) == 0);
      prioWrIdx = 8'($urandom_range(0, 255));
      prioWrData = 2'($urandom_range(0, 3));
    end
    @(negedge clk); pendReq = '0; prioWrEn = 1'b0;
    repeat (2) @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule